// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a watchdog for a small controller. Once software switches it on, it counts prescaled ticks. If software does not service it before a fixed number of ticks has elapsed, it raises a reset request. The system reset logic, which is not part of this block, acts on that request. Servicing takes two writes to the watchdog key port with no other key write between them: first 0x0A, then 0x03. Any other pattern leaves the count as it was.

The enable is write-once from the software side. A control write with the enable bit at 1 switches the watchdog on. After that, control writes cannot switch it off. Only the block's reset input, which the system drives from the power-on reset and the external reset pin, returns it to the disabled state. The tick input is a single-cycle strobe from a slow time base. For example, a 32768 Hz tick with the default terminal count of 65536 gives a 2 second timeout. Key and control writes are single-cycle strobes, and every strobe is accepted in the cycle it is presented. No stream flows through this block, so its pins are plain strobes with no valid/ready pair and no back-pressure.

Top module: `keyed_watchdog`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it is released, `wd_enabled_o` is 0 and `wd_rst_req_o` is 0.
- R2: A cycle with `ctrl_wr_i` = 1 and `ctrl_en_bit_i` = 1 sets `wd_enabled_o` to 1 from the following cycle onward.
- R3: Once `wd_enabled_o` is 1, control writes with `ctrl_en_bit_i` = 0 do not clear it and do not disturb the count. Only `rst_n` low returns it to 0.
- R4: A key write of 0x0A followed by a key write of 0x03, with no other key write between them, restarts the count from zero. The next reset request then comes a full TIMEOUT_TICKS ticks after the 0x03 write.
- R5: While the watchdog is enabled and not serviced, `wd_rst_req_o` is high for exactly one cycle in the cycle after the TIMEOUT_TICKS-th tick. Counting then restarts from zero, so the next request follows another TIMEOUT_TICKS ticks.
- R6: A key sequence that is out of order (0x03 before 0x0A), that uses a wrong second value, or that has another key write between 0x0A and 0x03 does not change the count.
- R7: A key write of 0x0A always starts the sequence again, even when the previous key write was also 0x0A. So 0x0A, 0x0A, 0x03 services the watchdog.
- R8: While the watchdog is disabled, ticks do not advance the count and `wd_rst_req_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset, driven by power-on reset or the reset pin |
| tick_i | input | 1 | Single-cycle time base strobe |
| ctrl_wr_i | input | 1 | Control register write strobe |
| ctrl_en_bit_i | input | 1 | Enable bit value carried by a control write |
| key_wr_i | input | 1 | Watchdog key register write strobe |
| key_data_i | input | KEY_W | Key value carried by a key write |
| wd_enabled_o | output | 1 | Watchdog is running |
| wd_rst_req_o | output | 1 | One-cycle reset request on timeout |

## Verification
The assertions assume that TIMEOUT_TICKS is at least 2, so that two timeout pulses can never fall on adjacent cycles. They also assume that `rst_n` is held low across at least one rising clock edge before the inputs are checked. The bench drives every tick, key and control strobe for exactly one cycle, changes it on the falling edge, and leaves at least one idle cycle between key writes. It uses a terminal count of 8, so the timeout and restart cases come up many times within a short run.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  // Progress through the two-write service key
  typedef enum logic {
    KS_IDLE  = 1'b0,
    KS_ARMED = 1'b1
  } key_state_e;

  localparam int unsigned KEY_W_DEF      = 8;
  localparam logic [7:0]  KEY_FIRST_DEF  = 8'h0A;
  localparam logic [7:0]  KEY_SECOND_DEF = 8'h03;

endpackage

// File: rtl/wdog_enable_lock.sv
module wdog_enable_lock (
  input  logic clk,
  input  logic rst_n,
  input  logic ctrl_wr_i,
  input  logic ctrl_en_bit_i,
  output logic en_o
);

  logic en_q;

  // Set-only: a control write can raise the enable, never lower it
  always_ff @(posedge clk) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= en_q | (ctrl_wr_i & ctrl_en_bit_i);
  end

  assign en_o = en_q;

  AST_EN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |=> en_q); // R3

  AST_EN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr_i && ctrl_en_bit_i) |=> en_q); // R2

endmodule

// File: rtl/wdog_key_seq.sv
module wdog_key_seq
  import wdog_pkg::*;
#(
  parameter int unsigned      KEY_W      = KEY_W_DEF,
  parameter logic [KEY_W-1:0] KEY_FIRST  = KEY_W'(KEY_FIRST_DEF),
  parameter logic [KEY_W-1:0] KEY_SECOND = KEY_W'(KEY_SECOND_DEF)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             key_wr_i,
  input  logic [KEY_W-1:0] key_data_i,
  output logic             kick_o
);

  key_state_e st_q;
  logic       kick_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= KS_IDLE;
      kick_q <= 1'b0;
    end else begin
      kick_q <= 1'b0;
      if (key_wr_i) begin
        if (key_data_i == KEY_FIRST) begin
          // first key always (re)starts the sequence
          st_q <= KS_ARMED;
        end else if (st_q == KS_ARMED && key_data_i == KEY_SECOND) begin
          kick_q <= 1'b1;
          st_q   <= KS_IDLE;
        end else begin
          // any other write abandons a partial sequence
          st_q <= KS_IDLE;
        end
      end
    end
  end

  assign kick_o = kick_q;

  AST_KICK_FROM_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
    kick_q |-> ($past(key_wr_i) && $past(key_data_i) == KEY_SECOND)); // R4

  AST_KICK_NOT_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    kick_q |=> !kick_q); // R6

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int unsigned TIMEOUT_TICKS = 65536
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic tick_i,
  input  logic kick_i,
  output logic req_o
);

  localparam int unsigned CNT_W = (TIMEOUT_TICKS > 2) ? $clog2(TIMEOUT_TICKS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_TICKS - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             req_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      req_q <= 1'b0;
    end else begin
      req_q <= 1'b0;
      if (!en_i) begin
        cnt_q <= '0;
      end else if (kick_i) begin
        cnt_q <= '0;
      end else if (tick_i) begin
        if (cnt_q == LAST) begin
          cnt_q <= '0;
          req_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign req_o = req_q;

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |-> (cnt_q == '0 && !req_q)); // R8

  AST_KICK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    kick_i |=> (cnt_q == '0)); // R4

  AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |=> !req_q); // R5

  AST_REQ_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |-> (cnt_q == '0)); // R5

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST); // R5

endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
  import wdog_pkg::*;
#(
  parameter int unsigned      TIMEOUT_TICKS = 65536,
  parameter int unsigned      KEY_W         = KEY_W_DEF,
  parameter logic [KEY_W-1:0] KEY_FIRST     = KEY_W'(KEY_FIRST_DEF),
  parameter logic [KEY_W-1:0] KEY_SECOND    = KEY_W'(KEY_SECOND_DEF)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             ctrl_wr_i,
  input  logic             ctrl_en_bit_i,
  input  logic             key_wr_i,
  input  logic [KEY_W-1:0] key_data_i,
  output logic             wd_enabled_o,
  output logic             wd_rst_req_o
);

  logic en;
  logic kick;

  wdog_enable_lock u_lock (
    .clk           (clk),
    .rst_n         (rst_n),
    .ctrl_wr_i     (ctrl_wr_i),
    .ctrl_en_bit_i (ctrl_en_bit_i),
    .en_o          (en)
  );

  wdog_key_seq #(
    .KEY_W      (KEY_W),
    .KEY_FIRST  (KEY_FIRST),
    .KEY_SECOND (KEY_SECOND)
  ) u_key (
    .clk        (clk),
    .rst_n      (rst_n),
    .key_wr_i   (key_wr_i),
    .key_data_i (key_data_i),
    .kick_o     (kick)
  );

  wdog_counter #(
    .TIMEOUT_TICKS (TIMEOUT_TICKS)
  ) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_i   (en),
    .tick_i (tick_i),
    .kick_i (kick),
    .req_o  (wd_rst_req_o)
  );

  assign wd_enabled_o = en;

  AST_REQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    wd_rst_req_o |-> wd_enabled_o); // R8

endmodule

// File: tb/sim_keyed_watchdog.sv
`timescale 1ns/1ps
module sim_keyed_watchdog;

  localparam int TC = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_i = 1'b0;
  logic       ctrl_wr_i = 1'b0;
  logic       ctrl_en_bit_i = 1'b0;
  logic       key_wr_i = 1'b0;
  logic [7:0] key_data_i = 8'h00;
  logic       wd_enabled_o;
  logic       wd_rst_req_o;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  keyed_watchdog #(.TIMEOUT_TICKS(TC)) u0 (
    .clk           (clk),
    .rst_n         (rst_n),
    .tick_i        (tick_i),
    .ctrl_wr_i     (ctrl_wr_i),
    .ctrl_en_bit_i (ctrl_en_bit_i),
    .key_wr_i      (key_wr_i),
    .key_data_i    (key_data_i),
    .wd_enabled_o  (wd_enabled_o),
    .wd_rst_req_o  (wd_rst_req_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one tick; returns req as seen after the edge that took it
  task automatic pulse_tick(output logic req);
    @(negedge clk) tick_i = 1'b1;
    @(negedge clk) tick_i = 1'b0;
    req = wd_rst_req_o;
  endtask

  task automatic ticks(input int n);
    logic r;
    for (int i = 0; i < n; i++) pulse_tick(r);
  endtask

  // number of ticks up to and including the one that raises the request, -1 if none
  task automatic count_to_req(input int max, output int n);
    logic r;
    n = -1;
    for (int i = 1; i <= max; i++) begin
      pulse_tick(r);
      if (r) begin
        n = i;
        break;
      end
    end
  endtask

  task automatic key_write(input logic [7:0] v);
    @(negedge clk) begin key_wr_i = 1'b1; key_data_i = v; end
    @(negedge clk) key_wr_i = 1'b0;
  endtask

  task automatic ctrl_write(input logic b);
    @(negedge clk) begin ctrl_wr_i = 1'b1; ctrl_en_bit_i = b; end
    @(negedge clk) ctrl_wr_i = 1'b0;
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(wd_enabled_o == 1'b0, "R1 enabled in reset", wd_enabled_o, 0);
    check(wd_rst_req_o == 1'b0, "R1 req in reset", wd_rst_req_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(wd_enabled_o == 1'b0 && wd_rst_req_o == 1'b0, "R1 after release",
          {wd_enabled_o, wd_rst_req_o}, 0);
  endtask

  task automatic t_disabled;
    int n;
    count_to_req(3 * TC, n);
    check(n == -1, "R8 no request while disabled", n, -1);
  endtask

  task automatic t_enable_timeout;
    int n;
    ctrl_write(1'b1);
    check(wd_enabled_o == 1'b1, "R2 enable set", wd_enabled_o, 1);
    count_to_req(4 * TC, n);
    check(n == TC, "R5 first timeout", n, TC);
    @(negedge clk);
    check(wd_rst_req_o == 1'b0, "R5 request lasts one cycle", wd_rst_req_o, 0);
    count_to_req(4 * TC, n);
    check(n == TC, "R5 restart after timeout", n, TC);
  endtask

  task automatic t_sticky;
    int n;
    ctrl_write(1'b0);
    check(wd_enabled_o == 1'b1, "R3 disable write ignored", wd_enabled_o, 1);
    count_to_req(4 * TC, n);
    check(n == TC, "R3 count undisturbed", n, TC);
  endtask

  task automatic t_service;
    int n;
    ticks(TC - 2);
    key_write(8'h0A);
    key_write(8'h03);
    count_to_req(4 * TC, n);
    check(n == TC, "R4 service restarts count", n, TC);
  endtask

  task automatic t_bad_order;
    int n;
    ticks(TC - 2);
    key_write(8'h03);
    key_write(8'h0A);
    count_to_req(4 * TC, n);
    check(n == 2, "R6 reversed keys ignored", n, 2);
    key_write(8'h55);
  endtask

  task automatic t_interrupted;
    int n;
    ticks(TC - 2);
    key_write(8'h0A);
    key_write(8'h55);
    key_write(8'h03);
    count_to_req(4 * TC, n);
    check(n == 2, "R6 interrupted sequence ignored", n, 2);
  endtask

  task automatic t_wrong_second;
    int n;
    ticks(TC - 2);
    key_write(8'h0A);
    key_write(8'h04);
    count_to_req(4 * TC, n);
    check(n == 2, "R6 wrong second key ignored", n, 2);
  endtask

  task automatic t_rearm;
    int n;
    ticks(TC - 2);
    key_write(8'h0A);
    key_write(8'h0A);
    key_write(8'h03);
    count_to_req(4 * TC, n);
    check(n == TC, "R7 repeated first key rearms", n, TC);
  endtask

  task automatic t_pin_reset;
    int n;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(wd_enabled_o == 1'b0, "R3 reset disables", wd_enabled_o, 0);
    count_to_req(2 * TC, n);
    check(n == -1, "R8 disabled after reset", n, -1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_disabled();
    t_enable_timeout();
    t_sticky();
    t_service();
    t_bad_order();
    t_interrupted();
    t_wrong_second();
    t_rearm();
    t_pin_reset();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule